// File: doc/BRIEF.md
# Flash query and OTP mode controller

This block sits behind the bus interface of a NOR-style flash model and turns committed write cycles into mode changes. It watches each write (address and low data byte) through an unlock-style command sequencer and keeps the mode of the device: normal array reads, a query mode that serves a small parameter table, an overlay mode where the lowest 256 word addresses reach a one-time-programmable bank, an identification mode that reports lock status, and a bypass mode that shortens program sequences.

Reads are served one clock after the read address is applied, from whichever source the current mode selects. Programming only ever clears bits. The OTP bank carries a customer lock that, once set, cannot be cleared by any command or by a hardware reset, and a factory lock fixed by a parameter. The main array and query table are small placeholders.

Top module: `fqo_ctrl`

## Requirements
- R1: While and after the synchronous hardware reset, all mode outputs are 0 and reads return main array words. Every main word starts at FFFFh.
- R2: A write of 98h to word address 055h enters query mode. Reads then return the query byte on bits 7:0 with bits 15:8 at 00h. The table holds 51h, 52h, 59h at word addresses 010h, 011h, 012h and 00h at every other low address byte.
- R3: Query mode is left only by a write whose low byte is F0h, at any address. All other writes in query mode have no effect.
- R4: The sequence AAh@555h, 55h@2AAh, 88h@555h enters OTP mode. Reads at 000h–0FFh then return OTP words (each starting at FFFFh). Reads at 100h and above still reach the main array.
- R5: The sequence AAh@555h, 55h@2AAh, A0h@555h followed by one write of data D to address A sets the word to its old value AND D. In OTP mode with A below 100h the OTP word is changed, otherwise the main word.
- R6: OTP mode ends on AAh@555h, 55h@2AAh, 90h@555h, 00h@any, or on hardware reset. An F0h write does not end it.
- R7: In OTP mode, AAh@555h, 55h@2AAh, 60h@555h followed by 60h@any sets the customer lock. The lock survives hardware reset, and every later OTP program is rejected, leaving the word unchanged.
- R8: AAh@555h, 55h@2AAh, 90h@555h enters the identification mode. A read at low address byte 02h returns bit 6 = customer lock, bit 7 = factory lock, all other bits 0. Other addresses read 0000h. A 00h write leaves the mode.
- R9: AAh@555h, 55h@2AAh, 20h@555h enters bypass mode, but is refused while OTP mode is on. In bypass mode A0h@any then data@address programs, and 90h@any then 00h@any leaves bypass.
- R10: The accelerated-program indication is the accelerate input registered, forced to 0 while OTP mode is on.
- R11: A cycle that does not match the expected step of a sequence returns the sequencer to idle without any action. An F0h write aborts a partial sequence.
- R12: rd_data reflects the rd_addr applied before the most recent clock edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Qualified write-commit pulse |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data; commands use bits 7:0 |
| rd_addr | input | ADDR_W | Read word address |
| accel_pin | input | 1 | Accelerated programming request |
| rd_data | output | DATA_W | Read data, one cycle after rd_addr |
| mode_query | output | 1 | Query mode active |
| mode_otp | output | 1 | OTP overlay mode active |
| mode_ident | output | 1 | Identification mode active |
| mode_bypass | output | 1 | Bypass mode active |
| accel_active | output | 1 | Accelerated programming granted |

## Verification
The sequencer is driven with complete sequences for each mode, with the same sequences carrying one corrupted address or an early F0h, and with commands sent while a mode is held. Complete sequences show that each mode is entered and routes reads to the right source; corrupted ones tell a sequencer that returns to idle apart from one that resumes mid-sequence; held-mode commands separate modes that ignore writes from ones that react. Repeated programs of one OTP word separate AND-programming from overwrite, and a program after locking, together with a reset between lock and readback, separates a lasting lock from a volatile one.

// File: rtl/fqo_pkg.sv
package fqo_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNLK1,
    SQ_UNLK2,
    SQ_PROG,
    SQ_LOCK,
    SQ_BEXIT
  } seq_t;

  typedef enum logic [1:0] {
    SRC_MAIN,
    SRC_OTP,
    SRC_QUERY,
    SRC_IDENT
  } rdsrc_t;

  localparam logic [7:0] CMD_UNLK1  = 8'hAA;
  localparam logic [7:0] CMD_UNLK2  = 8'h55;
  localparam logic [7:0] CMD_QUERY  = 8'h98;
  localparam logic [7:0] CMD_OTP    = 8'h88;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_BYPASS = 8'h20;
  localparam logic [7:0] CMD_LOCK   = 8'h60;
  localparam logic [7:0] CMD_RESET  = 8'hF0;
  localparam logic [7:0] CMD_ZERO   = 8'h00;

  localparam logic [11:0] ADR_FIRST = 12'h555;
  localparam logic [11:0] ADR_SECND = 12'h2AA;
  localparam logic [11:0] ADR_QUERY = 12'h055;
  localparam logic [7:0]  ADR_LOCKS = 8'h02;

  // placeholder parameter table, indexed by the low address byte
  function automatic logic [7:0] query_byte(input logic [7:0] idx);
    logic [7:0] b;
    case (idx)
      8'h10:   b = 8'h51;
      8'h11:   b = 8'h52;
      8'h12:   b = 8'h59;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/fqo_cmd_seq.sv
module fqo_cmd_seq
  import fqo_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              query_mode,
  output logic              otp_mode,
  output logic              ident_mode,
  output logic              bypass_mode,
  output logic              prog_fire,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              lock_fire
);

  localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(ADR_FIRST);
  localparam logic [ADDR_W-1:0] A_SECND = ADDR_W'(ADR_SECND);
  localparam logic [ADDR_W-1:0] A_QUERY = ADDR_W'(ADR_QUERY);

  seq_t       seq;
  logic [7:0] cmd;

  assign cmd = wr_data[7:0];

  always_ff @(posedge clk) begin
    prog_fire <= 1'b0;
    lock_fire <= 1'b0;
    if (rst) begin
      seq         <= SQ_IDLE;
      query_mode  <= 1'b0;
      otp_mode    <= 1'b0;
      ident_mode  <= 1'b0;
      bypass_mode <= 1'b0;
      prog_addr   <= '0;
      prog_data   <= '0;
    end else if (wr_en) begin
      if (cmd == CMD_RESET && seq != SQ_PROG) begin
        seq        <= SQ_IDLE;
        query_mode <= 1'b0;
        ident_mode <= 1'b0;
      end else if (query_mode) begin
        seq <= SQ_IDLE;
      end else if (ident_mode) begin
        if (cmd == CMD_ZERO) begin
          ident_mode <= 1'b0;
          otp_mode   <= 1'b0;
        end
      end else begin
        seq <= SQ_IDLE;
        case (seq)
          SQ_IDLE: begin
            if (bypass_mode) begin
              if (cmd == CMD_PROG)       seq <= SQ_PROG;
              else if (cmd == CMD_IDENT) seq <= SQ_BEXIT;
            end else if (cmd == CMD_QUERY && wr_addr == A_QUERY) begin
              query_mode <= 1'b1;
            end else if (cmd == CMD_UNLK1 && wr_addr == A_FIRST) begin
              seq <= SQ_UNLK1;
            end
          end
          SQ_UNLK1: begin
            if (cmd == CMD_UNLK2 && wr_addr == A_SECND) seq <= SQ_UNLK2;
          end
          SQ_UNLK2: begin
            if (wr_addr == A_FIRST) begin
              case (cmd)
                CMD_OTP:    otp_mode   <= 1'b1;
                CMD_IDENT:  ident_mode <= 1'b1;
                CMD_PROG:   seq        <= SQ_PROG;
                CMD_BYPASS: if (!otp_mode) bypass_mode <= 1'b1;
                CMD_LOCK:   if (otp_mode) seq <= SQ_LOCK;
                default:    ;
              endcase
            end
          end
          SQ_PROG: begin
            prog_fire <= 1'b1;
            prog_addr <= wr_addr;
            prog_data <= wr_data;
          end
          SQ_LOCK: begin
            if (cmd == CMD_LOCK) lock_fire <= 1'b1;
          end
          SQ_BEXIT: begin
            if (cmd == CMD_ZERO) bypass_mode <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  AST_QUERY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (query_mode && !(wr_en && cmd == CMD_RESET)) |=> query_mode); // R3

  AST_NO_BYPASS_IN_OTP: assert property (@(posedge clk) disable iff (rst)
    !(otp_mode && bypass_mode)); // R9

  AST_RESET_CLEARS_MODES: assert property (@(posedge clk)
    rst |=> (!otp_mode && !query_mode && !ident_mode && !bypass_mode)); // R1

  AST_LOCK_ONLY_IN_OTP: assert property (@(posedge clk) disable iff (rst)
    lock_fire |-> otp_mode); // R7

endmodule

// File: rtl/fqo_main_bank.sv
module fqo_main_bank #(
  parameter int DATA_W = 16,
  parameter int WORDS  = 1024,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              prog_en,
  input  logic [AW-1:0]     prog_idx,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [AW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_q
);

  logic [DATA_W-1:0] mem [WORDS];

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (prog_en) mem[prog_idx] <= mem[prog_idx] & prog_data;
    rd_q <= mem[rd_idx];
  end

endmodule

// File: rtl/fqo_otp_bank.sv
module fqo_otp_bank #(
  parameter int DATA_W       = 16,
  parameter int WORDS        = 256,
  parameter bit FACTORY_LOCK = 1'b0,
  localparam int AW          = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              prog_en,
  input  logic [AW-1:0]     prog_idx,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              lock_en,
  input  logic [AW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_q,
  output logic              cust_locked,
  output logic              fact_locked
);

  logic [DATA_W-1:0] mem [WORDS];
  logic              cust_lock = 1'b0;
  logic              write_ok;

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = '1;
  end

  assign write_ok    = prog_en && !cust_lock && !FACTORY_LOCK;
  assign cust_locked = cust_lock;
  assign fact_locked = FACTORY_LOCK;

  // lock bit is non-volatile: hardware reset does not touch it
  always_ff @(posedge clk) begin
    if (lock_en) cust_lock <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (write_ok) mem[prog_idx] <= mem[prog_idx] & prog_data;
    rd_q <= mem[rd_idx];
  end

  AST_LOCK_STICKY: assert property (@(posedge clk)
    cust_lock |=> cust_lock); // R7

endmodule

// File: rtl/fqo_ctrl.sv
module fqo_ctrl
  import fqo_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 16,
  parameter int MAIN_WORDS   = 1024,
  parameter int OTP_WORDS    = 256,
  parameter bit FACTORY_LOCK = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              accel_pin,
  output logic [DATA_W-1:0] rd_data,
  output logic              mode_query,
  output logic              mode_otp,
  output logic              mode_ident,
  output logic              mode_bypass,
  output logic              accel_active
);

  localparam int MAIN_AW = $clog2(MAIN_WORDS);
  localparam int OTP_AW  = $clog2(OTP_WORDS);
  localparam logic [ADDR_W-1:0] OTP_LIMIT = ADDR_W'(OTP_WORDS);

  logic              prog_fire, lock_fire;
  logic [ADDR_W-1:0] prog_addr;
  logic [DATA_W-1:0] prog_data;
  logic              prog_in_otp;
  logic [DATA_W-1:0] main_q, otp_q;
  logic              cust_locked, fact_locked;
  rdsrc_t            src_q;
  logic [7:0]        qbyte_q;
  logic [1:0]        locks_q;

  fqo_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .query_mode  (mode_query),
    .otp_mode    (mode_otp),
    .ident_mode  (mode_ident),
    .bypass_mode (mode_bypass),
    .prog_fire   (prog_fire),
    .prog_addr   (prog_addr),
    .prog_data   (prog_data),
    .lock_fire   (lock_fire)
  );

  assign prog_in_otp = mode_otp && (prog_addr < OTP_LIMIT);

  fqo_main_bank #(.DATA_W(DATA_W), .WORDS(MAIN_WORDS)) u_main (
    .clk       (clk),
    .prog_en   (prog_fire && !prog_in_otp),
    .prog_idx  (prog_addr[MAIN_AW-1:0]),
    .prog_data (prog_data),
    .rd_idx    (rd_addr[MAIN_AW-1:0]),
    .rd_q      (main_q)
  );

  fqo_otp_bank #(.DATA_W(DATA_W), .WORDS(OTP_WORDS), .FACTORY_LOCK(FACTORY_LOCK)) u_otp (
    .clk         (clk),
    .prog_en     (prog_fire && prog_in_otp),
    .prog_idx    (prog_addr[OTP_AW-1:0]),
    .prog_data   (prog_data),
    .lock_en     (lock_fire),
    .rd_idx      (rd_addr[OTP_AW-1:0]),
    .rd_q        (otp_q),
    .cust_locked (cust_locked),
    .fact_locked (fact_locked)
  );

  // read source and small-table data registered alongside the bank reads
  always_ff @(posedge clk) begin
    if (mode_query)                           src_q <= SRC_QUERY;
    else if (mode_ident)                      src_q <= SRC_IDENT;
    else if (mode_otp && rd_addr < OTP_LIMIT) src_q <= SRC_OTP;
    else                                      src_q <= SRC_MAIN;
    qbyte_q <= query_byte(rd_addr[7:0]);
    locks_q <= (rd_addr[7:0] == ADR_LOCKS) ? {fact_locked, cust_locked} : 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst) accel_active <= 1'b0;
    else     accel_active <= accel_pin && !mode_otp;
  end

  always_comb begin
    case (src_q)
      SRC_QUERY: rd_data = {{(DATA_W-8){1'b0}}, qbyte_q};
      SRC_IDENT: rd_data = {{(DATA_W-8){1'b0}}, locks_q, 6'b000000};
      SRC_OTP:   rd_data = otp_q;
      default:   rd_data = main_q;
    endcase
  end

  AST_ACCEL_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (mode_otp && $past(mode_otp)) |-> !accel_active); // R10

  AST_PROG_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    (prog_fire && cust_locked && prog_in_otp) |=> cust_locked); // R7

endmodule

// File: tb/fqo_ctrl_test.sv
module fqo_ctrl_test;

  localparam int AW = 12;
  localparam int DW = 16;
  localparam logic [1:0] OPW = 2'd0;
  localparam logic [1:0] OPR = 2'd1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic          accel_pin = 1'b0;
  logic [DW-1:0] rd_data;
  logic          mode_query, mode_otp, mode_ident, mode_bypass, accel_active;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  fqo_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .accel_pin(accel_pin), .rd_data(rd_data),
    .mode_query(mode_query), .mode_otp(mode_otp), .mode_ident(mode_ident),
    .mode_bypass(mode_bypass), .accel_active(accel_active)
  );

  function automatic logic [49:0] mk(input logic [1:0] op, input logic [11:0] a,
                                     input logic [15:0] d, input logic [15:0] e,
                                     input logic [3:0] tag);
    return {op, a, d, e, tag};
  endfunction

  localparam int NV = 54;
  localparam logic [49:0] VEC [NV] = '{
    mk(OPR, 12'h000, 16'h0000, 16'hFFFF, 4'd1),   // R1 erased main
    mk(OPW, 12'h555, 16'h00AA, 16'h0000, 4'd5),
    mk(OPW, 12'h2AA, 16'h0055, 16'h0000, 4'd5),
    mk(OPW, 12'h555, 16'h00A0, 16'h0000, 4'd5),
    mk(OPW, 12'h010, 16'h1234, 16'h0000, 4'd5),
    mk(OPR, 12'h010, 16'h0000, 16'h1234, 4'd5),   // R5 main program
    mk(OPW, 12'h055, 16'h0098, 16'h0000, 4'd2),
    mk(OPR, 12'h010, 16'h0000, 16'h0051, 4'd2),   // R2 query table
    mk(OPR, 12'h011, 16'h0000, 16'h0052, 4'd2),
    mk(OPR, 12'h012, 16'h0000, 16'h0059, 4'd2),
    mk(OPR, 12'h013, 16'h0000, 16'h0000, 4'd2),
    mk(OPW, 12'h555, 16'h00AA, 16'h0000, 4'd3),
    mk(OPW, 12'h2AA, 16'h0055, 16'h0000, 4'd3),
    mk(OPW, 12'h555, 16'h0088, 16'h0000, 4'd3),
    mk(OPR, 12'h010, 16'h0000, 16'h0051, 4'd3),   // R3 writes ignored
    mk(OPW, 12'h123, 16'h00F0, 16'h0000, 4'd3),
    mk(OPR, 12'h010, 16'h0000, 16'h1234, 4'd3),   // R3 reset command exits
    mk(OPW, 12'h555, 16'h00AA, 16'h0000, 4'd4),
    mk(OPW, 12'h2AA, 16'h0055, 16'h0000, 4'd4),
    mk(OPW, 12'h555, 16'h0088, 16'h0000, 4'd4),
    mk(OPR, 12'h010, 16'h0000, 16'hFFFF, 4'd4),   // R4 OTP overlay
    mk(OPR, 12'h110, 16'h0000, 16'hFFFF, 4'd4),   // R4 above overlay: main
    mk(OPW, 12'h555, 16'h00AA, 16'h0000, 4'd5),
    mk(OPW, 12'h2AA, 16'h0055, 16'h0000, 4'd5),
    mk(OPW, 12'h555, 16'h00A0, 16'h0000, 4'd5),
    mk(OPW, 12'h010, 16'h5A5A, 16'h0000, 4'd5),
    mk(OPR, 12'h010, 16'h0000, 16'h5A5A, 4'd5),   // R5 OTP program
    mk(OPW, 12'h555, 16'h00AA, 16'h0000, 4'd5),
    mk(OPW, 12'h2AA, 16'h0055, 16'h0000, 4'd5),
    mk(OPW, 12'h555, 16'h00A0, 16'h0000, 4'd5),
    mk(OPW, 12'h010, 16'h0FF0, 16'h0000, 4'd5),
    mk(OPR, 12'h010, 16'h0000, 16'h0A50, 4'd5),   // R5 AND only
    mk(OPW, 12'h000, 16'h00F0, 16'h0000, 4'd6),
    mk(OPR, 12'h010, 16'h0000, 16'h0A50, 4'd6),   // R6 F0 keeps OTP
    mk(OPW, 12'h555, 16'h00AA, 16'h0000, 4'd6),
    mk(OPW, 12'h2AA, 16'h0055, 16'h0000, 4'd6),
    mk(OPW, 12'h555, 16'h0090, 16'h0000, 4'd6),
    mk(OPW, 12'h000, 16'h0000, 16'h0000, 4'd6),
    mk(OPR, 12'h010, 16'h0000, 16'h1234, 4'd6),   // R6 exit sequence
    mk(OPW, 12'h555, 16'h00AA, 16'h0000, 4'd11),
    mk(OPW, 12'h2AB, 16'h0055, 16'h0000, 4'd11),
    mk(OPW, 12'h555, 16'h0088, 16'h0000, 4'd11),
    mk(OPR, 12'h010, 16'h0000, 16'h1234, 4'd11),  // R11 bad address
    mk(OPW, 12'h555, 16'h00AA, 16'h0000, 4'd11),
    mk(OPW, 12'h2AA, 16'h0055, 16'h0000, 4'd11),
    mk(OPW, 12'h000, 16'h00F0, 16'h0000, 4'd11),
    mk(OPW, 12'h555, 16'h0088, 16'h0000, 4'd11),
    mk(OPR, 12'h010, 16'h0000, 16'h1234, 4'd11),  // R11 F0 aborts
    mk(OPW, 12'h555, 16'h00AA, 16'h0000, 4'd8),
    mk(OPW, 12'h2AA, 16'h0055, 16'h0000, 4'd8),
    mk(OPW, 12'h555, 16'h0090, 16'h0000, 4'd8),
    mk(OPR, 12'h002, 16'h0000, 16'h0000, 4'd8),   // R8 unlocked status
    mk(OPW, 12'h000, 16'h0000, 16'h0000, 4'd8),
    mk(OPR, 12'h010, 16'h0000, 16'h1234, 4'd8)    // R8 ident left
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input int tag,
                     input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [15:0] e, input int tag);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    chk(rd_data, e, tag, "read");
  endtask

  task automatic unlock(input logic [7:0] c);
    wr(12'h555, 16'h00AA);
    wr(12'h2AA, 16'h0055);
    wr(12'h555, {8'h00, c});
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state of mode outputs
    chk({11'b0, mode_query, mode_otp, mode_ident, mode_bypass, accel_active}, 16'h0, 1,
        "modes in reset");
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][49:48] == OPW) wr(VEC[i][47:36], VEC[i][35:20]);
      else                      rd_chk(VEC[i][47:36], VEC[i][19:4], int'(VEC[i][3:0]));
    end

    // R7 set customer lock, then read it through identification mode (R8)
    unlock(8'h88);
    unlock(8'h60);
    wr(12'h000, 16'h0060);
    unlock(8'h90);
    rd_chk(12'h002, 16'h0040, 8);
    rd_chk(12'h005, 16'h0000, 8);
    wr(12'h000, 16'h0000);
    chk({15'b0, mode_otp}, 16'h0, 6, "otp after exit");          // R6

    // R7 program after lock is rejected
    unlock(8'h88);
    unlock(8'hA0);
    wr(12'h010, 16'h0000);
    rd_chk(12'h010, 16'h0A50, 7);

    // R10 accelerate refused in OTP mode, R9 bypass refused in OTP mode
    accel_pin = 1'b1;
    @(negedge clk);
    chk({15'b0, accel_active}, 16'h0, 10, "accel in otp");
    unlock(8'h20);
    chk({15'b0, mode_bypass}, 16'h0, 9, "bypass in otp");

    // R6 hardware reset leaves OTP mode; R10 accelerate granted again
    hw_reset();
    chk({15'b0, mode_otp}, 16'h0, 6, "otp after hw reset");
    chk({15'b0, accel_active}, 16'h1, 10, "accel outside otp");
    rd_chk(12'h010, 16'h1234, 6);

    // R7 lock survives hardware reset
    unlock(8'h88);
    unlock(8'h90);
    rd_chk(12'h002, 16'h0040, 7);
    wr(12'h000, 16'h0000);

    // R9 bypass programming and exit
    unlock(8'h20);
    chk({15'b0, mode_bypass}, 16'h1, 9, "bypass entered");
    wr(12'h000, 16'h00A0);
    wr(12'h020, 16'h00FF);
    rd_chk(12'h020, 16'h00FF, 9);
    wr(12'h000, 16'h0090);
    wr(12'h000, 16'h0000);
    chk({15'b0, mode_bypass}, 16'h0, 9, "bypass left");

    // R12 one cycle read latency
    @(negedge clk);
    rd_addr = 12'h020;
    @(negedge clk);
    rd_addr = 12'h010;
    #1;
    chk(rd_data, 16'h00FF, 12, "before edge");
    @(negedge clk);
    chk(rd_data, 16'h1234, 12, "after edge");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule